// File: doc/BRIEF.md
# Probabilistic Neighbor Row Refresh Generator

This block sits in the command path of a DRAM controller and reacts to every row close (precharge). On each close it makes an independent random decision: with a small programmable probability, it asks the command scheduler to activate one row physically adjacent to the row that was just closed. The only purpose of that activation is to restore the charge in the neighbor. No data moves, and no per-row history is kept. Repeated opening of a single aggressor row therefore leads, with high probability, to its victims being refreshed before coupling-induced leakage can flip their bits.

The probability is a 16-bit threshold compared against a pseudo-random sample, so a value near 328 gives about 0.5 %. A 17-bit shift register supplies the sample and one further bit that chooses the direction. Requests go to the scheduler over a valid/ready handshake. A four-entry queue absorbs requests that the scheduler has not yet taken. Requests that arrive while the queue is full are discarded and counted. The shift register can be loaded with a chosen seed, so a sequence can be replayed.

Top module: `nbr_refresh_gen`

## Requirements
- R1: While rst_n is low, req_valid is 0 and drop_count is 0. Reset leaves the random state at the value 17'h00001.
- R2: The random state S is 17 bits wide. It advances once in each cycle in which pre_valid is 1, and the next value is {S[15:0], S[16]^S[13]}. In other cycles it holds. When seed_load is 1, the state takes seed_value on the next edge instead, or 17'h00001 if seed_value is zero. The load has priority over advancing.
- R3: A precharge triggers a request only when S[15:0] < prob_thresh, comparing unsigned values and using the state in force before that edge. When prob_thresh is 0, no request is ever produced.
- R4: The request carries the bank of the precharge. If S[16] is 1, its row is pre_row+1. If S[16] is 0, its row is pre_row-1. Each trigger produces exactly one request.
- R5: At row 0 the target is always row 1. At the last row (all ones) the target is always the last row minus 1, whatever the value of S[16].
- R6: A triggered request is presented on req_valid, req_bank and req_row from the edge after the precharge cycle when the queue was empty. It stays stable until an edge where req_valid and req_ready are both 1.
- R7: Pending requests are held in a first-in first-out queue of four entries and are presented in trigger order.
- R8: A trigger that finds four entries queued, with no pop at that same edge, is discarded and increments drop_count by one. drop_count is 16 bits wide and saturates at its maximum. A pop at the same edge makes room for the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_valid | input | 1 | A row close happens this cycle |
| pre_bank | input | BANK_W | Bank of the closed row |
| pre_row | input | ROW_W | Address of the closed row |
| prob_thresh | input | 16 | Trigger threshold (probability times 65536) |
| seed_load | input | 1 | Load seed_value into the random state |
| seed_value | input | 17 | Seed for the random state |
| req_valid | output | 1 | A neighbor activation request is pending |
| req_ready | input | 1 | Scheduler accepts the request |
| req_bank | output | BANK_W | Bank of the row to refresh |
| req_row | output | ROW_W | Row to refresh |
| drop_count | output | 16 | Saturating count of discarded triggers |

## Verification
On every cycle, the assertions check that each trigger targets a row adjacent to the closed one in the same bank, and that the edge rows turn inward. They also check that a zero threshold never triggers, that a request held back by the scheduler stays stable, that the queue never overfills, and that the drop counter moves by at most one step. Only the bench scenarios, which run a shift-register model seeded like the design, can show the following: that a given sequence of closes yields exactly the predicted decisions and directions, that a reloaded seed or a zero seed replays correctly, that the queue keeps order under back-pressure, and that a pop and a trigger at the same edge on a full queue lose nothing.

// File: rtl/nrr_pkg.sv
package nrr_pkg;
  localparam int LFSR_W   = 17;
  localparam int SAMPLE_W = 16;
  localparam int TAP_A    = 16;
  localparam int TAP_B    = 13;
  localparam logic [LFSR_W-1:0] LFSR_INIT = LFSR_W'(1);

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[TAP_A] ^ s[TAP_B]};
  endfunction
endpackage

// File: rtl/nrr_lfsr.sv
module nrr_lfsr (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step,
  input  logic                       load,
  input  logic [nrr_pkg::LFSR_W-1:0] seed,
  output logic [nrr_pkg::LFSR_W-1:0] state
);
  logic [nrr_pkg::LFSR_W-1:0] state_d;
  logic                       state_en;

  always_comb begin
    state_en = load | step;
    if (load) state_d = (seed == '0) ? nrr_pkg::LFSR_INIT : seed;
    else      state_d = nrr_pkg::lfsr_next(state);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= nrr_pkg::LFSR_INIT;
    else if (state_en) state <= state_d;
  end
endmodule

// File: rtl/nrr_neighbor.sv
module nrr_neighbor #(
  parameter int ROW_W = 10
) (
  input  logic [ROW_W-1:0] row,
  input  logic             go_up,
  output logic [ROW_W-1:0] target
);
  localparam logic [ROW_W-1:0] FIRST_ROW = '0;
  localparam logic [ROW_W-1:0] LAST_ROW  = '1;
  localparam logic [ROW_W-1:0] ONE       = ROW_W'(1);

  logic use_up;

  always_comb begin
    if (row == FIRST_ROW)     use_up = 1'b1;
    else if (row == LAST_ROW) use_up = 1'b0;
    else                      use_up = go_up;
    target = use_up ? (row + ONE) : (row - ONE);
  end
endmodule

// File: rtl/nrr_fifo.sv
module nrr_fifo #(
  parameter int DATA_W = 13,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              accepted,
  output logic              not_empty,
  output logic [DATA_W-1:0] head,
  output logic [$clog2(DEPTH+1)-1:0] occupancy
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr, rd_ptr_d, wr_ptr_d;
  logic [CNT_W-1:0]  cnt, cnt_d;
  logic              do_pop, do_push;

  always_comb begin
    do_pop   = pop && (cnt != '0);
    do_push  = push && ((cnt != FULL_CNT) || do_pop);
    accepted = do_push;
    rd_ptr_d = do_pop  ? ((rd_ptr == LAST_PTR) ? '0 : rd_ptr + PTR_W'(1)) : rd_ptr;
    wr_ptr_d = do_push ? ((wr_ptr == LAST_PTR) ? '0 : wr_ptr + PTR_W'(1)) : wr_ptr;
    cnt_d    = cnt + CNT_W'(do_push) - CNT_W'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      rd_ptr <= rd_ptr_d;
      wr_ptr <= wr_ptr_d;
      cnt    <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wr_ptr == PTR_W'(i))) mem[i] <= push_data;
    end
  end

  assign not_empty = (cnt != '0);
  assign head      = mem[rd_ptr];
  assign occupancy = cnt;
endmodule

// File: rtl/nbr_refresh_gen.sv
module nbr_refresh_gen #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 10,
  parameter int QDEPTH = 4,
  parameter int DROP_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pre_valid,
  input  logic [BANK_W-1:0]            pre_bank,
  input  logic [ROW_W-1:0]             pre_row,
  input  logic [nrr_pkg::SAMPLE_W-1:0] prob_thresh,
  input  logic                         seed_load,
  input  logic [nrr_pkg::LFSR_W-1:0]   seed_value,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic [BANK_W-1:0]            req_bank,
  output logic [ROW_W-1:0]             req_row,
  output logic [DROP_W-1:0]            drop_count
);
  localparam int ENT_W = BANK_W + ROW_W;
  localparam int OCC_W = $clog2(QDEPTH+1);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic [nrr_pkg::LFSR_W-1:0]   rnd;
  logic [nrr_pkg::SAMPLE_W-1:0] sample;
  logic                         go_up;
  logic                         fire;
  logic [ROW_W-1:0]             tgt_row;
  logic                         q_accept;
  logic [ENT_W-1:0]             q_head;
  logic [OCC_W-1:0]             q_occ;
  logic                         drop_en;
  logic [DROP_W-1:0]            drop_d;

  nrr_lfsr i_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (pre_valid),
    .load  (seed_load),
    .seed  (seed_value),
    .state (rnd)
  );

  assign sample = rnd[nrr_pkg::SAMPLE_W-1:0];
  assign go_up  = rnd[nrr_pkg::LFSR_W-1];
  assign fire   = pre_valid && (sample < prob_thresh);

  nrr_neighbor #(.ROW_W(ROW_W)) i_nbr (
    .row    (pre_row),
    .go_up  (go_up),
    .target (tgt_row)
  );

  nrr_fifo #(.DATA_W(ENT_W), .DEPTH(QDEPTH)) i_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fire),
    .push_data ({pre_bank, tgt_row}),
    .pop       (req_ready),
    .accepted  (q_accept),
    .not_empty (req_valid),
    .head      (q_head),
    .occupancy (q_occ)
  );

  assign {req_bank, req_row} = q_head;

  always_comb begin
    drop_en = fire && !q_accept && (drop_count != DROP_MAX);
    drop_d  = drop_count + DROP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       drop_count <= '0;
    else if (drop_en) drop_count <= drop_d;
  end
endmodule

// File: rtl/nbr_refresh_gen_chk.sv
module nbr_refresh_gen_chk #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 10,
  parameter int QDEPTH = 4,
  parameter int DROP_W = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         pre_valid,
  input logic [BANK_W-1:0]            pre_bank,
  input logic [ROW_W-1:0]             pre_row,
  input logic [nrr_pkg::SAMPLE_W-1:0] prob_thresh,
  input logic                         req_valid,
  input logic                         req_ready,
  input logic [BANK_W-1:0]            req_bank,
  input logic [ROW_W-1:0]             req_row,
  input logic [DROP_W-1:0]            drop_count,
  input logic                         fire,
  input logic [ROW_W-1:0]             tgt_row,
  input logic [$clog2(QDEPTH+1)-1:0]  q_occ
);
  localparam logic [ROW_W-1:0] ONE      = ROW_W'(1);
  localparam logic [ROW_W-1:0] LAST_ROW = '1;

  // R4
  adjacent_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> ((tgt_row == pre_row + ONE) || (tgt_row == pre_row - ONE)));

  // R5
  low_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pre_row == '0) |-> (tgt_row == ONE));

  // R5
  high_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pre_row == LAST_ROW) |-> (tgt_row == LAST_ROW - ONE));

  // R3
  zero_prob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_valid && prob_thresh == '0) |-> !fire);

  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_bank) && $stable(req_row)));

  // R7
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_occ <= QDEPTH);

  // R8
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(drop_count));

  // R8
  drop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + DROP_W'(1))));
endmodule

bind nbr_refresh_gen nbr_refresh_gen_chk #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .QDEPTH(QDEPTH), .DROP_W(DROP_W)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pre_valid   (pre_valid),
  .pre_bank    (pre_bank),
  .pre_row     (pre_row),
  .prob_thresh (prob_thresh),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_bank    (req_bank),
  .req_row     (req_row),
  .drop_count  (drop_count),
  .fire        (fire),
  .tgt_row     (tgt_row),
  .q_occ       (q_occ)
);

// File: tb/test_nbr_refresh_gen.sv
module test_nbr_refresh_gen;
  localparam int BANK_W = 3;
  localparam int ROW_W  = 10;
  localparam int DEPTH  = 4;
  localparam logic [ROW_W-1:0] LAST = '1;

  logic              clk;
  logic              rst_n;
  logic              pre_valid;
  logic [BANK_W-1:0] pre_bank;
  logic [ROW_W-1:0]  pre_row;
  logic [15:0]       prob_thresh;
  logic              seed_load;
  logic [16:0]       seed_value;
  logic              req_valid;
  logic              req_ready;
  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0]  req_row;
  logic [15:0]       drop_count;

  nbr_refresh_gen #(.BANK_W(BANK_W), .ROW_W(ROW_W)) i_nbr_refresh_gen (
    .clk(clk), .rst_n(rst_n), .pre_valid(pre_valid), .pre_bank(pre_bank),
    .pre_row(pre_row), .prob_thresh(prob_thresh), .seed_load(seed_load),
    .seed_value(seed_value), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .drop_count(drop_count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [16:0]             ms;
  logic [BANK_W+ROW_W-1:0] mq [DEPTH];
  string                   mt [DEPTH];
  int                      mcnt;
  int                      mdrops;

  function automatic logic [16:0] step_state(input logic [16:0] s);
    return {s[15:0], s[16] ^ s[13]};
  endfunction

  function automatic logic [ROW_W-1:0] nbr_of(input logic [ROW_W-1:0] r, input logic up);
    if (r == '0)   return ROW_W'(1);
    if (r == LAST) return LAST - ROW_W'(1);
    return up ? r + ROW_W'(1) : r - ROW_W'(1);
  endfunction

  task automatic check_outputs(input string ph);
    vectors++;
    if (req_valid !== (mcnt > 0)) begin
      errors++;
      $display("FAIL %s req_valid actual %0b expected %0b", ph, req_valid, mcnt > 0);
    end
    if (mcnt > 0) begin
      vectors++;
      if ({req_bank, req_row} !== mq[0]) begin
        errors++;
        $display("FAIL %s/%s request actual bank %0d row %0d expected bank %0d row %0d",
                 ph, mt[0], req_bank, req_row, mq[0][BANK_W+ROW_W-1:ROW_W], mq[0][ROW_W-1:0]);
      end
    end
    vectors++;
    if (drop_count !== 16'(mdrops)) begin
      errors++;
      $display("FAIL R8 (%s) drop_count actual %0d expected %0d", ph, drop_count, mdrops);
    end
  endtask

  task automatic cycle(input logic pv, input logic [BANK_W-1:0] bk, input logic [ROW_W-1:0] rw,
                       input logic [15:0] thr, input logic rdy, input logic sl,
                       input logic [16:0] sv, input string ph);
    logic was_full, pop;
    logic [ROW_W-1:0] tgt;
    check_outputs(ph);
    pre_valid = pv; pre_bank = bk; pre_row = rw; prob_thresh = thr;
    req_ready = rdy; seed_load = sl; seed_value = sv;
    was_full = (mcnt == DEPTH);
    pop = (mcnt > 0) && rdy;
    if (pop) begin
      for (int i = 0; i < DEPTH-1; i++) begin mq[i] = mq[i+1]; mt[i] = mt[i+1]; end
      mcnt--;
    end
    if (pv && (ms[15:0] < thr)) begin
      if (was_full && !pop) begin
        if (mdrops < 65535) mdrops++;
      end else begin
        tgt = nbr_of(rw, ms[16]);
        mq[mcnt] = {bk, tgt};
        mt[mcnt] = (rw == '0 || rw == LAST) ? "R5" : "R4";
        mcnt++;
      end
    end
    if (sl) ms = (sv == '0) ? 17'h1 : sv;
    else if (pv) ms = step_state(ms);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [ROW_W-1:0] pick_row();
    int k = $urandom_range(0, 7);
    if (k == 0) return '0;
    if (k == 1) return LAST;
    return ROW_W'($urandom);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; pre_valid = 0; pre_bank = 0; pre_row = 0; prob_thresh = 0;
    req_ready = 0; seed_load = 0; seed_value = 0;
    ms = 17'h1; mcnt = 0; mdrops = 0;
    repeat (3) @(negedge clk);
    check_outputs("R1");
    rst_n = 1'b1;

    // R2: seed load then events following the stated recurrence
    cycle(0, 0, 0, 16'h0, 1, 1, 17'h1ACE5, "R2");
    for (int i = 0; i < 40; i++)
      cycle(1, BANK_W'($urandom), pick_row(), 16'h8000, 1, 0, 0, "R2");

    // R3: zero threshold never produces a request
    for (int i = 0; i < 200; i++)
      cycle(1'($urandom), BANK_W'($urandom), pick_row(), 16'h0, 1'($urandom), 0, 0, "R3");

    // R7 / R8: fill the queue with ready low, overflow, then drain in order
    for (int i = 0; i < 9; i++)
      cycle(1, BANK_W'(i), ROW_W'(100 + 7*i), 16'hFFFF, 0, 0, 0, "R7");
    for (int i = 0; i < 6; i++)
      cycle(0, 0, 0, 16'hFFFF, 1, 0, 0, "R7");
    for (int i = 0; i < 6; i++)
      cycle(1, BANK_W'(i), ROW_W'(300 + i), 16'hFFFF, 0, 0, 0, "R8");
    // R8: full queue with a pop at the same edge keeps the trigger
    cycle(1, 3'd5, ROW_W'(555), 16'hFFFF, 1, 0, 0, "R8");
    for (int i = 0; i < 6; i++)
      cycle(0, 0, 0, 16'hFFFF, 1, 0, 0, "R8");

    // R5: closes at both edge rows
    for (int i = 0; i < 40; i++)
      cycle(1, BANK_W'($urandom), (i % 2 == 0) ? ROW_W'(0) : LAST, 16'hFFFF, 1, 0, 0, "R5");

    // R2: zero seed falls back to one, and a repeated seed replays
    cycle(0, 0, 0, 16'h0, 1, 1, 17'h0, "R2");
    for (int i = 0; i < 30; i++)
      cycle(1, BANK_W'($urandom), pick_row(), 16'h8000, 1, 0, 0, "R2");
    cycle(0, 0, 0, 16'h0, 1, 1, 17'h1ACE5, "R2");
    for (int i = 0; i < 30; i++)
      cycle(1, BANK_W'($urandom), pick_row(), 16'h8000, 1, 0, 0, "R2");

    // R6: random traffic with back-pressure and mixed probabilities
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] thr;
      int sel = $urandom_range(0, 3);
      thr = (sel == 0) ? 16'd328 : (sel == 1) ? 16'h8000 : (sel == 2) ? 16'hFFFF : 16'($urandom);
      cycle(($urandom_range(0, 9) < 7), BANK_W'($urandom), pick_row(), thr,
            ($urandom_range(0, 9) < 6), 0, 0, "R6");
    end
    for (int i = 0; i < 8; i++)
      cycle(0, 0, 0, 16'h0, 1, 0, 0, "R6");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule